// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block collects up to 64 active-low interrupt sources and presents them to software through a small bank of 32-bit registers. The state for each source is split over a high bank and a low bank. The mapping from source number to bank and bit position follows a fixed but irregular table: source number does not equal bit position. Software enables sources through mask words and acknowledges latched edge events by writing ones to the pending words. It reads a vector word that names the lowest-numbered source that is both pending and enabled. A single request output rises whenever any enabled source is pending.

Sources fall into three classes, and the sense control depends on the class. Internal sources are always level-low. External-pin sources (19..25) can be set to level-low or falling-edge. Port-pin sources (48..63) can be set to both-edge or falling-edge. Every raw input passes through a two-flop synchronizer before any detection. Edge events are held until software clears them. A level source reports pending exactly while its input is low.

Register map (byte addresses; any other address reads zero and ignores writes): 0x00 mask high, 0x04 mask low, 0x08 pending high, 0x0C pending low, 0x10 sense control, 0x14 vector (read-only). Reads are combinational from the current state. A write takes effect at the clock edge where `bus_wr` is high.

Top module: `xmap_intc`

## Requirements
- R1: Source s maps as follows. s=1..15 go to high bit 16-s. s=16..18 go to low bits 2,1,0. s=19..30 go to low bit 33-s. s=32..47 go to high bit 63-s. s=48..63 go to low bit s-32. Sources 0 and 31 are unused: their inputs are ignored, and high bit 0 and low bit 15 always read 0 in the mask and pending words.
- R2: A mask bit of 1 enables its source and 0 blocks it. Both mask words are 0 after reset, and mask bits of unused positions read 0.
- R3: Writing 1 to a pending bit clears a latched edge event. Writing 0 leaves it unchanged, and writing 0xFFFFFFFF clears every latched event in that word.
- R4: The vector word holds, in bits 31:26, the lowest-numbered source that is pending and unmasked. Its other bits are 0, and the word reads 0 when no such source exists.
- R5: `irq_o` is 1 exactly when some source is both pending and unmasked.
- R6: External source s (19..25) uses sense bit 33-s (source 19 uses bit 14, source 25 uses bit 8). With that bit at 1, a falling edge latches pending. With it at 0, the source is level-low.
- R7: Port source s (48..63) uses sense bit s-32. With that bit at 1, only falling edges latch pending. With it at 0 (the reset value), both edges latch pending.
- R8: Internal sources are level-low: pending follows the input and cannot be cleared while the input is low. Only sense bits 31:16 and 14:8 are writable, so writing all ones reads back 0xFFFF7F00.
- R9: An input change reaches the pending word after two clock edges and not after one.
- R10: Pending bits report source activity regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_n | input | 64 | Raw active-low interrupt sources, bit index = source number |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Assertions check on every cycle that the request output and a non-zero vector agree, and that the vector names a source that is really requesting with no lower-numbered one also requesting. They also check that a latched edge event persists until cleared, that a clear removes it, and that the masks come out of reset empty. The irregular bank and bit table, the per-class sense behaviour, the two-cycle synchronizer latency and the write-one-to-clear rules on level sources cannot be seen by a local property. The bench's scenarios show them by driving source pins and reading the register words back.

// File: rtl/xmap_intc_pkg.sv
// Package: shared constants, types and the source-to-register mapping.
// Assumes exactly 64 sources; the mapping functions encode the fixed table.
package xmap_intc_pkg;

    localparam int NUM_SRC = 64;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int REG_W   = 32;
    localparam int BIT_W   = $clog2(REG_W);

    // Byte offsets of the register words
    localparam int OFS_MASK_HI = 'h00;
    localparam int OFS_MASK_LO = 'h04;
    localparam int OFS_PEND_HI = 'h08;
    localparam int OFS_PEND_LO = 'h0C;
    localparam int OFS_SENSE   = 'h10;
    localparam int OFS_VECTOR  = 'h14;

    // Writable bits of the sense-control word
    localparam logic [REG_W-1:0] SENSE_WMASK = 32'hFFFF_7F00;

    typedef enum logic [1:0] {
        CLS_UNUSED = 2'd0,
        CLS_INTERN = 2'd1,
        CLS_EXTPIN = 2'd2,
        CLS_PORT   = 2'd3
    } src_cls_e;

    // Class of a source number
    function automatic src_cls_e src_class(input int s);
        if (s == 0 || s == 31)      return CLS_UNUSED;
        if (s >= 19 && s <= 25)     return CLS_EXTPIN;
        if (s >= 48)                return CLS_PORT;
        return CLS_INTERN;
    endfunction

    // True when the source lives in the low bank
    function automatic logic src_in_low(input int s);
        return ((s >= 16 && s <= 31) || s >= 48);
    endfunction

    // Bit position of a source inside its bank
    function automatic int src_bitpos(input int s);
        if (s == 0)       return 0;
        else if (s < 16)  return 16 - s;
        else if (s < 19)  return 18 - s;
        else if (s < 31)  return 33 - s;
        else if (s == 31) return 0;
        else if (s < 48)  return 63 - s;
        else              return s - 32;
    endfunction

    // Bit of the sense-control word that governs a source (0 if none)
    function automatic int src_sensebit(input int s);
        if (s >= 19 && s <= 25) return 33 - s;
        if (s >= 48)            return s - 32;
        return 0;
    endfunction

endpackage

// File: rtl/xmap_intc_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes inputs are idle-high; all stages reset to RST_VAL.
module xmap_intc_sync #(
    parameter int          WIDTH   = 64,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= {WIDTH{RST_VAL}};
                else        stg[g] <= d_i;
            end
        end else begin : g_next
            // Later stages shift the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= {WIDTH{RST_VAL}};
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/xmap_intc_cell.sv
// Module: per-source sense detection and pending latch.
// Assumes src_i is synchronized and active-low; CLS fixes which sense
// options exist. Edge events latch until clr_i; level sources report live.
module xmap_intc_cell
    import xmap_intc_pkg::*;
#(
    parameter src_cls_e CLS = CLS_INTERN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic sense_i,
    input  logic clr_i,
    output logic pend_o
);

    logic prev_q;
    logic latch_q;
    logic edge_mode;
    logic fall;
    logic rise;
    logic hit;

    // Select edge or level operation for this class and sense bit
    always_comb begin
        case (CLS)
            CLS_EXTPIN: edge_mode = sense_i;
            CLS_PORT:   edge_mode = 1'b1;
            default:    edge_mode = 1'b0;
        endcase
    end

    assign fall = prev_q & ~src_i;
    assign rise = ~prev_q & src_i;
    assign hit  = (CLS == CLS_PORT && !sense_i) ? (fall | rise) : fall;

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= src_i;
    end

    // Latch edge events; a new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !edge_mode) latch_q <= 1'b0;
        else if (hit)             latch_q <= 1'b1;
        else if (clr_i)           latch_q <= 1'b0;
    end

    // Report latched state in edge mode, live low level otherwise
    always_comb begin
        if (CLS == CLS_UNUSED) pend_o = 1'b0;
        else if (edge_mode)    pend_o = latch_q;
        else                   pend_o = ~src_i;
    end

    // A latched event persists until a clear arrives
    p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $past(edge_mode) && $past(latch_q) && !$past(clr_i)) |-> latch_q);

    // A clear without a coincident edge removes the event
    p_clear_works_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $past(edge_mode) && $past(clr_i) && !$past(hit)) |-> !latch_q);

endmodule

// File: rtl/xmap_intc_prio.sv
// Module: fixed-priority encoder, lowest index wins.
// Assumes index 0 never requests (it doubles as the "none" code).
module xmap_intc_prio #(
    parameter int N = 64,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic [W-1:0] idx_o,
    output logic         any_o
);

    // Scan from the top so the lowest requesting index is left standing
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = W'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xmap_intc.sv
// Module: top of the scrambled-map interrupt controller.
// Holds mask and sense registers, scatters/gathers per-source state to the
// high/low register words through the fixed table, and drives the vector
// and request output. Assumes single-cycle register writes and a
// combinational read port.
module xmap_intc
    import xmap_intc_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic                irq_o
);

    localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(OFS_MASK_HI);
    localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(OFS_MASK_LO);
    localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(OFS_PEND_HI);
    localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(OFS_PEND_LO);
    localparam logic [ADDR_W-1:0] A_SENSE   = ADDR_W'(OFS_SENSE);
    localparam logic [ADDR_W-1:0] A_VECTOR  = ADDR_W'(OFS_VECTOR);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] sense_of;
    logic [REG_W-1:0]   sense_q;
    logic [REG_W-1:0]   mask_hi_v, mask_lo_v, pend_hi_v, pend_lo_v;
    logic [SRC_W-1:0]   vec;
    logic               vec_any;
    logic               wr_mask_hi, wr_mask_lo, wr_pend_hi, wr_pend_lo, wr_sense;

    assign wr_mask_hi = bus_wr && (bus_addr == A_MASK_HI);
    assign wr_mask_lo = bus_wr && (bus_addr == A_MASK_LO);
    assign wr_pend_hi = bus_wr && (bus_addr == A_PEND_HI);
    assign wr_pend_lo = bus_wr && (bus_addr == A_PEND_LO);
    assign wr_sense   = bus_wr && (bus_addr == A_SENSE);

    xmap_intc_sync #(
        .WIDTH   (NUM_SRC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_n),
        .q_o   (src_sync)
    );

    // Mask register: scatter written words onto used sources only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (src_class(s) != CLS_UNUSED) begin
                    if (wr_mask_hi && !src_in_low(s))
                        mask_q[s] <= bus_wdata[src_bitpos(s)];
                    if (wr_mask_lo && src_in_low(s))
                        mask_q[s] <= bus_wdata[src_bitpos(s)];
                end
            end
        end
    end

    // Sense-control register: only the defined fields hold state
    always_ff @(posedge clk) begin
        if (!rst_n)        sense_q <= '0;
        else if (wr_sense) sense_q <= bus_wdata & SENSE_WMASK;
    end

    // Per-source clear strobes and sense selections from the register words
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_in_low(s)) clr[s] = wr_pend_lo && bus_wdata[src_bitpos(s)];
            else               clr[s] = wr_pend_hi && bus_wdata[src_bitpos(s)];
            sense_of[s] = (src_class(s) == CLS_EXTPIN || src_class(s) == CLS_PORT)
                          ? sense_q[src_sensebit(s)] : 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        xmap_intc_cell #(
            .CLS (src_class(g))
        ) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_sync[g]),
            .sense_i (sense_of[g]),
            .clr_i   (clr[g]),
            .pend_o  (pend[g])
        );
    end

    // Gather per-source mask and pending bits into the register views
    always_comb begin
        mask_hi_v = '0;
        mask_lo_v = '0;
        pend_hi_v = '0;
        pend_lo_v = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_class(s) != CLS_UNUSED) begin
                if (src_in_low(s)) begin
                    mask_lo_v[src_bitpos(s)] = mask_q[s];
                    pend_lo_v[src_bitpos(s)] = pend[s];
                end else begin
                    mask_hi_v[src_bitpos(s)] = mask_q[s];
                    pend_hi_v[src_bitpos(s)] = pend[s];
                end
            end
        end
    end

    xmap_intc_prio #(
        .N (NUM_SRC),
        .W (SRC_W)
    ) i_prio (
        .req_i (pend & mask_q),
        .idx_o (vec),
        .any_o (vec_any)
    );

    assign irq_o = |(pend & mask_q);

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            A_MASK_HI: bus_rdata = mask_hi_v;
            A_MASK_LO: bus_rdata = mask_lo_v;
            A_PEND_HI: bus_rdata = pend_hi_v;
            A_PEND_LO: bus_rdata = pend_lo_v;
            A_SENSE:   bus_rdata = sense_q;
            A_VECTOR:  bus_rdata = {vec, {(REG_W - SRC_W){1'b0}}};
            default:   bus_rdata = '0;
        endcase
    end

    // Request output and a non-zero vector always agree
    p_irq_vec_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec != '0));

    // The reported source is really pending and enabled
    p_vec_is_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_any |-> (pend[vec] && mask_q[vec]));

    // No lower-numbered source is active than the one reported
    p_vec_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_any |-> (((pend & mask_q) & ((64'd1 << vec) - 64'd1)) == '0));

    // Masks leave reset empty
    p_mask_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '0));

endmodule

// File: tb/test_xmap_intc.sv
`timescale 1ns/1ps
module test_xmap_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_n = '1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [4:0] MH = 5'h00, ML = 5'h04, PH = 5'h08, PL = 5'h0C,
                           SN = 5'h10, VC = 5'h14;

    always #2 clk = ~clk;

    xmap_intc i_xmap_intc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_n     (src_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic int exp_bit(input int s);
        if (s == 0) return 0;
        if (s < 16) return 16 - s;
        if (s < 19) return 18 - s;
        if (s < 31) return 33 - s;
        if (s == 31) return 0;
        if (s < 48) return 63 - s;
        return s - 32;
    endfunction

    function automatic bit exp_low(input int s);
        return (s >= 16 && s <= 31) || s >= 48;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(PH, 32'hFFFF_FFFF);
        wr(PL, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(MH, d); chk("R2 mask high after reset", d, 0);
        rd(ML, d); chk("R2 mask low after reset", d, 0);
        rd(PH, d); chk("R10 pending high idle", d, 0);
        rd(PL, d); chk("R10 pending low idle", d, 0);
        rd(VC, d); chk("R4 vector idle", d, 0);
        chk("R5 irq idle", 32'(irq_o), 0);
    endtask

    task automatic t_map();
        logic [31:0] dh, dl, eh, el;
        int list [12] = '{1, 5, 15, 16, 17, 18, 19, 30, 32, 47, 48, 63};
        foreach (list[k]) begin
            int s = list[k];
            @(negedge clk); src_n[s] = 1'b0;
            settle();
            eh = exp_low(s) ? 32'd0 : (32'd1 << exp_bit(s));
            el = exp_low(s) ? (32'd1 << exp_bit(s)) : 32'd0;
            rd(PH, dh); rd(PL, dl);
            chk($sformatf("R1 map src %0d high", s), dh, eh);
            chk($sformatf("R1 map src %0d low", s), dl, el);
            @(negedge clk); src_n[s] = 1'b1;
            settle();
            clear_all();
        end
    endtask

    task automatic t_sync();
        logic [31:0] d;
        @(negedge clk); src_n[5] = 1'b0;
        @(negedge clk); rd(PH, d);
        chk("R9 not visible after one edge", d, 0);
        @(negedge clk); rd(PH, d);
        chk("R9 visible after two edges", d, 32'd1 << 11);
        @(negedge clk); src_n[5] = 1'b1;
        settle();
    endtask

    task automatic t_mask_vec();
        logic [31:0] d;
        @(negedge clk); src_n[40] = 1'b0; src_n[10] = 1'b0;
        settle();
        rd(PH, d); chk("R10 pending while masked", d, (32'd1 << 23) | (32'd1 << 6));
        chk("R5 irq low while masked", 32'(irq_o), 0);
        rd(VC, d); chk("R4 vector zero while masked", d, 0);
        wr(MH, 32'd1 << 23);
        rd(VC, d); chk("R4 vector single source", d, 32'd40 << 26);
        chk("R5 irq high unmasked", 32'(irq_o), 1);
        wr(MH, (32'd1 << 23) | (32'd1 << 6));
        rd(VC, d); chk("R4 lowest number wins", d, 32'd10 << 26);
        rd(MH, d); chk("R2 mask readback", d, (32'd1 << 23) | (32'd1 << 6));
        wr(MH, 32'd1 << 23);
        rd(VC, d); chk("R4 masked source skipped", d, 32'd40 << 26);
        @(negedge clk); src_n[40] = 1'b1; src_n[10] = 1'b1;
        settle();
        chk("R5 irq drops after release", 32'(irq_o), 0);
        wr(MH, 0);
    endtask

    task automatic t_port();
        logic [31:0] d;
        wr(SN, 32'd1 << 18);
        @(negedge clk); src_n[50] = 1'b0;
        settle();
        rd(PL, d); chk("R7 falling edge latches", d, 32'd1 << 18);
        wr(PL, 32'd0);
        rd(PL, d); chk("R3 write zero no effect", d, 32'd1 << 18);
        wr(PL, 32'd1 << 18);
        rd(PL, d); chk("R3 write one clears", d, 0);
        @(negedge clk); src_n[50] = 1'b1;
        settle();
        rd(PL, d); chk("R7 rising ignored in falling mode", d, 0);
        wr(SN, 32'd0);
        @(negedge clk); src_n[50] = 1'b0;
        settle();
        wr(PL, 32'd1 << 18);
        @(negedge clk); src_n[50] = 1'b1;
        settle();
        rd(PL, d); chk("R7 rising latches in both-edge mode", d, 32'd1 << 18);
        @(negedge clk); src_n[49] = 1'b0; src_n[60] = 1'b0;
        settle();
        rd(PL, d); chk("R7 two port latches", d, (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 28));
        wr(PL, 32'hFFFF_FFFF);
        rd(PL, d); chk("R3 all ones clears every latch", d, 0);
        @(negedge clk); src_n[49] = 1'b1; src_n[60] = 1'b1;
        settle();
        clear_all();
    endtask

    task automatic t_ext();
        logic [31:0] d;
        @(negedge clk); src_n[22] = 1'b0;
        settle();
        rd(PL, d); chk("R6 level mode pending", d, 32'd1 << 11);
        @(negedge clk); src_n[22] = 1'b1;
        settle();
        rd(PL, d); chk("R6 level mode follows release", d, 0);
        wr(SN, 32'd1 << 11);
        @(negedge clk); src_n[22] = 1'b0;
        settle();
        @(negedge clk); src_n[22] = 1'b1;
        settle();
        rd(PL, d); chk("R6 edge mode holds after release", d, 32'd1 << 11);
        wr(PL, 32'd1 << 11);
        rd(PL, d); chk("R6 edge mode cleared", d, 0);
        wr(SN, 32'd1 << 14);
        @(negedge clk); src_n[19] = 1'b0;
        settle();
        @(negedge clk); src_n[19] = 1'b1;
        settle();
        rd(PL, d); chk("R6 source 19 uses sense bit 14", d, 32'd1 << 14);
        clear_all();
        wr(SN, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); src_n[3] = 1'b0;
        settle();
        wr(PH, 32'd1 << 13);
        rd(PH, d); chk("R8 clear ignored while active", d, 32'd1 << 13);
        @(negedge clk); src_n[3] = 1'b1;
        settle();
        rd(PH, d); chk("R8 level drops on release", d, 0);
        wr(SN, 32'hFFFF_FFFF);
        rd(SN, d); chk("R8 sense writable fields", d, 32'hFFFF_7F00);
        wr(SN, 32'd0);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        wr(MH, 32'hFFFF_FFFF);
        wr(ML, 32'hFFFF_FFFF);
        rd(MH, d); chk("R1 mask high unused bit 0", d, 32'hFFFF_FFFE);
        rd(ML, d); chk("R1 mask low unused bit 15", d, 32'hFFFF_7FFF);
        @(negedge clk); src_n[0] = 1'b0; src_n[31] = 1'b0;
        settle();
        rd(PH, d); chk("R1 source 0 ignored", d, 0);
        rd(PL, d); chk("R1 source 31 ignored", d, 0);
        chk("R5 no irq from unused", 32'(irq_o), 0);
        @(negedge clk); src_n[33] = 1'b0; src_n[61] = 1'b0;
        settle();
        rd(VC, d); chk("R4 lowest of 33 and 61", d, 32'd33 << 26);
        @(negedge clk); src_n = '1;
        settle();
        clear_all();
        rd(VC, d); chk("R4 vector clear at end", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_sync();
        t_mask_vec();
        t_port();
        t_ext();
        t_level();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule